// File: doc/BRIEF.md
# Pointer-Based I2C Register Access Target

This block is a serial bus target that lets an I2C master reach a small register file through an 8-bit register pointer. The bus clock and data lines are sampled on a fast system clock, which must run at least eight times the bus bit rate. Bus rates up to 400 kbit/s are supported. The block drives the data line only through an open-drain style pull-down enable, and an external pull-up supplies the high level. The master always drives the bus clock.

A write transaction carries the register number first, and that byte loads the pointer. Each later byte is stored at the pointed register through a one-cycle write strobe, and the pointer then steps by one. A read transaction returns the byte at the pointer and steps the pointer after each byte it sends. It keeps sending while the master acknowledges. The pointer keeps its value between transactions, so a master may read:
- from a chosen register, by sending a write-direction address and the register number, then a repeated START and a read-direction address;
- from wherever the previous access stopped, by sending the read-direction address alone.

The register contents are held outside the block. They are read combinationally through an address/data pair.

Top module: `ptr_i2c_target`

## Requirements
- R1: The block acknowledges (pulls the data line low in the ninth bit) only an address byte whose upper seven bits equal 7'b0001110. The last bit of the address byte selects the direction: 0 is write and 1 is read. With any other address it acknowledges nothing, writes nothing and leaves the pointer unchanged until the next START.
- R2: In a write transaction, the first byte after the address is acknowledged and loaded into the pointer. The new pointer is visible on `rf_raddr` once the byte completes.
- R3: Each further byte in a write transaction is acknowledged and written with a single-cycle `rf_we` pulse, with `rf_waddr` equal to the pointer and `rf_wdata` equal to the byte, MSB first on the bus. The pointer then increments by one, also when STOP follows at once.
- R4: A write-direction address, a register-number byte, a repeated START and a read-direction address make the block return, MSB first, the register at that number.
- R5: A read-direction address with no register-number phase returns the register at the pointer left by the previous transaction.
- R6: In a read, the pointer increments after every byte sent. The next register is sent after a master ACK. After a master NACK the data line stays released until the next START or STOP.
- R7: After reset the pointer is 0 and the data line is released. The pointer wraps from 255 to 0, for writes and for reads.
- R8: A STOP in any state ends the transfer and releases the data line. This includes a master ACK followed directly by STOP. A STOP in the middle of a transaction keeps the pointer value reached so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | When 1 the data line is pulled low; when 0 it is released |
| rf_we | output | 1 | Register write strobe, one cycle per stored byte |
| rf_waddr | output | 8 | Register number written |
| rf_wdata | output | 8 | Byte written |
| rf_raddr | output | 8 | Current register pointer, used as the read address |
| rf_rdata | input | 8 | Register contents at `rf_raddr` |

## Verification
Random transactions are mixed in a fixed-seed stream:
- burst writes of one to four bytes at random registers;
- reads from a defined location;
- reads from the current location;
- transfers to wrong addresses.

Each mix checks a different point. A defined-location read after a random write shows that the register-number phase and the auto-increment agree. A current-location read shows that the pointer carries over between transactions. A wrong address shows that neither the pointer nor the registers change. Directed cases cover the pointer wrap at 255, a STOP right after the register number, a master ACK followed by STOP, and a current-location read straight out of reset.

// File: rtl/ptr_i2c_target_pkg.sv
package ptr_i2c_target_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/ptr_i2c_rst_sync.sv
module ptr_i2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ptr_i2c_line_sync.sv
module ptr_i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/ptr_i2c_pointer.sv
module ptr_i2c_pointer #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == '1 && inc && !load) |=> (ptr_q == '0)); // R7
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == $past(load_val))); // R2
endmodule

// File: rtl/ptr_i2c_byte_fsm.sv
module ptr_i2c_byte_fsm
  import ptr_i2c_target_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'b0001110,
  parameter int unsigned PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ptr_load,
  output logic [PTR_W-1:0]  ptr_load_val,
  output logic              ptr_inc,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int unsigned CNT_W    = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              rw_q, rw_d;
  logic              first_q, first_d;
  logic              mack_q, mack_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic [PTR_W-1:0]  waddr_q, waddr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    rw_d     = rw_q;
    first_d  = first_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    we_d     = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
              state_d = ST_ADDR_ACK;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              first_d = 1'b1;
              state_d = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            oe_d    = 1'b1;
            state_d = ST_RX_ACK;
            if (first_q) begin
              ptr_load = 1'b1;
            end else begin
              we_d    = 1'b1;
              waddr_d = ptr;
              wdata_d = sh_q;
              ptr_inc = 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            first_d = 1'b0;
            state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              oe_d    = 1'b0;
              ptr_inc = 1'b1;
              state_d = ST_TX_ACK;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~tx_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign ptr_load_val = PTR_W'(sh_q);
  assign sda_oe       = oe_q;
  assign wr_en        = we_q;
  assign wr_addr      = waddr_q;
  assign wr_data      = wdata_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q); // R1
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!oe_q && state_q == ST_IDLE)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R6
endmodule

// File: rtl/ptr_i2c_target.sv
module ptr_i2c_target
  import ptr_i2c_target_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b0001110,
  parameter int unsigned PTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              rf_we,
  output logic [PTR_W-1:0]  rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic [PTR_W-1:0]  rf_raddr,
  input  logic [BYTE_W-1:0] rf_rdata
);
  logic             rst_n_s;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             ptr_load, ptr_inc;
  logic [PTR_W-1:0] ptr_load_val, ptr;

  ptr_i2c_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ptr_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ptr_i2c_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(ptr)
  );

  ptr_i2c_byte_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ptr(ptr), .rd_data(rf_rdata), .ptr_load(ptr_load),
    .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc), .sda_oe(sda_oe),
    .wr_en(rf_we), .wr_addr(rf_waddr), .wr_data(rf_wdata)
  );

  assign rf_raddr = ptr;

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: tb/ptr_i2c_target_bench.sv
module ptr_i2c_target_bench;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'b0001110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, rf_we;
  logic [7:0] rf_waddr, rf_wdata, rf_raddr, rf_rdata;
  wire sda_line = m_sda & ~sda_oe;

  logic [7:0] regs [256];
  assign rf_rdata = regs[rf_raddr];
  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  ptr_i2c_target u_ptr_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [6:0] bad_addr(logic [31:0] r);
    logic [6:0] a;
    a = r[6:0];
    if (a == DEV) a = a ^ 7'h40;
    return a;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(); qw();
  endtask

  task automatic bit_out(logic b);
    m_sda = b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); b = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic wr_byte(logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(s);
    ack = !s;
  endtask

  task automatic rd_byte(logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(!mack);
    m_sda = 1'b1;
  endtask

  task automatic txn_write(logic [7:0] rn, int n, logic stop_early);
    logic ack;
    logic [7:0] d;
    logic [7:0] base;
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    chk(ack, "R1", "write address ack", ack, 1);
    wr_byte(rn, ack);
    chk(ack, "R2", "register number ack", ack, 1);
    exp_ptr = rn;
    base = rn;
    if (!stop_early) begin
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        wr_byte(d, ack);
        chk(ack, "R3", "data byte ack", ack, 1);
        exp_mem[exp_ptr] = d;
        exp_ptr = exp_ptr + 8'd1;
      end
    end
    bus_stop();
    chk(rf_raddr == exp_ptr, "R3", "pointer after write", rf_raddr, exp_ptr);
    for (int k = 0; k < n && !stop_early; k++) begin
      logic [7:0] a;
      a = base + 8'(k);
      chk(regs[a] == exp_mem[a], "R3", "stored register", regs[a], exp_mem[a]);
    end
  endtask

  task automatic txn_read(logic defined, logic [7:0] rn, int n, logic last_ack);
    logic ack;
    logic [7:0] d;
    bus_start();
    if (defined) begin
      wr_byte({DEV, 1'b0}, ack);
      chk(ack, "R4", "address ack before pointer", ack, 1);
      wr_byte(rn, ack);
      chk(ack, "R4", "register number ack", ack, 1);
      exp_ptr = rn;
      bus_start();
    end
    wr_byte({DEV, 1'b1}, ack);
    chk(ack, "R1", "read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte((k < n - 1) || last_ack, d);
      if (defined)
        chk(d == exp_mem[exp_ptr], "R4", "defined read data", d, exp_mem[exp_ptr]);
      else
        chk(d == exp_mem[exp_ptr], "R5", "current read data", d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    if (!last_ack) begin
      qw();
      chk(sda_line == 1'b1, "R6", "line released after NACK", sda_line, 1);
    end
    bus_stop();
    chk(sda_line == 1'b1, "R8", "line released after STOP", sda_line, 1);
    chk(rf_raddr == exp_ptr, "R6", "pointer after read", rf_raddr, exp_ptr);
  endtask

  task automatic txn_bad(logic [6:0] a);
    logic ack;
    int we_seen;
    we_seen = 0;
    bus_start();
    wr_byte({a, 1'b0}, ack);
    chk(!ack, "R1", "foreign address not acked", ack, 0);
    fork
      begin
        wr_byte(8'($urandom), ack);
      end
      begin
        repeat (9 * 4 * Q) begin
          @(negedge clk);
          if (rf_we) we_seen++;
        end
      end
    join
    chk(!ack, "R1", "byte after foreign address not acked", ack, 0);
    chk(we_seen == 0, "R1", "no write after foreign address", we_seen, 0);
    bus_stop();
    chk(rf_raddr == exp_ptr, "R1", "pointer kept after foreign address", rf_raddr, exp_ptr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin
      regs[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    exp_ptr = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: reset state
    chk(sda_oe == 1'b0, "R7", "line released after reset", sda_oe, 0);
    chk(rf_we == 1'b0, "R7", "no write strobe after reset", rf_we, 0);
    chk(rf_raddr == 8'd0, "R7", "pointer zero after reset", rf_raddr, 0);

    // R5, R7: read current location straight out of reset
    txn_read(1'b0, 8'd0, 2, 1'b0);

    // R7: write wrap from 255 to 0
    txn_write(8'd255, 2, 1'b0);
    chk(rf_raddr == 8'd1, "R7", "pointer wrapped by write", rf_raddr, 1);
    // R7: read wrap
    txn_read(1'b1, 8'd254, 3, 1'b0);
    chk(rf_raddr == 8'd1, "R7", "pointer wrapped by read", rf_raddr, 1);

    // R2, R8: STOP right after the register number
    txn_write(8'd40, 0, 1'b1);
    chk(rf_raddr == 8'd40, "R8", "pointer kept on early STOP", rf_raddr, 40);

    // R8: master ACK then STOP; next register has MSB 1
    bus_start();
    wr_byte({DEV, 1'b0}, ack);
    wr_byte(8'd10, ack);
    wr_byte(8'h55, ack);
    wr_byte(8'hC3, ack);
    bus_stop();
    exp_mem[10] = 8'h55;
    exp_mem[11] = 8'hC3;
    exp_ptr = 8'd12;
    txn_read(1'b1, 8'd10, 1, 1'b1);
    chk(rf_raddr == 8'd11, "R8", "pointer after ACK then STOP", rf_raddr, 11);
    txn_read(1'b0, 8'd0, 1, 1'b0);

    // R1: foreign address
    txn_bad(7'b0001111);

    // random mix
    for (int t = 0; t < 40; t++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: txn_write(8'($urandom), 1 + int'($urandom % 4), 1'b0);
        1: txn_read(1'b1, 8'($urandom), 1 + int'($urandom % 4), 1'b0);
        2: txn_read(1'b0, 8'd0, 1 + int'($urandom % 4), 1'b0);
        default: txn_bad(bad_addr($urandom));
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule